// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit with Early-Exit Multiply

This block does unsigned integer multiplication and division one bit per clock cycle, using one shared sequential datapath. A single start strobe launches an operation. An operation select chooses a full-width multiply or a restoring divide, and two operands of equal width go with it. The unit raises a busy flag while it works. When the result is ready it gives a one-cycle done pulse. The results stay on the outputs until the next operation is accepted.

The multiplier operand is consumed from its least significant bit upward, one bit per cycle. The loop stops as soon as the multiplier bits not yet consumed are all zero, so a short multiplier finishes in few cycles. A divide always runs one iteration per quotient bit. A zero divisor skips the loop and returns an error pulse instead. An iteration counter output shows how many iterations the last operation used.

Top module: `iter_muldiv`

## Requirements
- R1: After reset, busy_o, done_o and div_err_o are low, and product_o, quotient_o, remainder_o and iter_count_o are zero.
- R2: With op_i = 0 (multiply), product_o takes the full 64-bit unsigned product opa_i * opb_i when done_o pulses.
- R3: A multiply runs max(1, p+1) iterations, where p is the index of the highest set bit of opb_i. iter_count_o reports that number. done_o rises at the (iterations+1)-th rising clock edge, counting the edge that samples start_i as the first.
- R4: A multiply with opb_i = 0 gives product 0, iter_count_o = 1, and done_o at the second edge.
- R5: With op_i = 1 (divide) and a nonzero opb_i, quotient_o = opa_i / opb_i and remainder_o = opa_i % opb_i. iter_count_o = 32, and done_o rises at the 33rd edge.
- R6: A divide with opb_i = 0 pulses done_o and div_err_o together at the second edge. It sets quotient_o and remainder_o to all ones and iter_count_o to 0.
- R7: start_i is ignored while busy_o is high. The operation in flight completes with the results and latency of its original operands.
- R8: done_o is high for exactly one cycle and never while busy_o is high. The result outputs change only in the cycle done_o is high.
- R9: A multiply leaves quotient_o and remainder_o unchanged. A divide leaves product_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch strobe, sampled when not busy |
| op_i | input | 1 | 0 = multiply, 1 = divide |
| opa_i | input | 32 | Multiplicand or dividend |
| opb_i | input | 32 | Multiplier or divisor |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| div_err_o | output | 1 | Divide-by-zero, pulses with done_o |
| product_o | output | 64 | Last multiply result |
| quotient_o | output | 32 | Last divide quotient |
| remainder_o | output | 32 | Last divide remainder |
| iter_count_o | output | 6 | Iterations used by the last operation |

## Verification
The assertions check on every cycle that done_o is a single pulse that never overlaps busy_o. They also check that the results stay frozen outside that pulse, that an error pulse always carries all-ones results, and that the iteration count stays below the operand width while busy. Arithmetic correctness, the data-dependent multiply latency and the fixed divide latency can only be shown by the bench's scenarios. The same goes for the zero-operand cases and for stray start pulses having no effect during an operation, which the bench compares against its own reference model.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_DIV  = 2'd2
    } md_state_e;

    localparam logic OP_MUL = 1'b0;
    localparam logic OP_DIV = 1'b1;
endpackage

// File: rtl/md_mul_step.sv
module md_mul_step #(
    parameter int W = 32
) (
    input  logic [2*W-1:0] mcand_i,
    input  logic [W-1:0]   mplier_i,
    input  logic [2*W-1:0] acc_i,
    output logic [2*W-1:0] mcand_o,
    output logic [W-1:0]   mplier_o,
    output logic [2*W-1:0] acc_o,
    output logic           last_o
);
    always_comb begin
        acc_o    = mplier_i[0] ? (acc_i + mcand_i) : acc_i;
        mcand_o  = mcand_i << 1;
        mplier_o = mplier_i >> 1;
        last_o   = (mplier_o == '0);
    end
endmodule

// File: rtl/md_div_step.sv
module md_div_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] quo_i,
    input  logic [W-1:0] dvsr_i,
    output logic [W-1:0] rem_o,
    output logic [W-1:0] quo_o
);
    logic [W:0] shifted;
    logic [W:0] diff;

    always_comb begin
        shifted = {rem_i, quo_i[W-1]};
        diff    = shifted - {1'b0, dvsr_i};
        if (!diff[W]) begin
            rem_o = diff[W-1:0];
            quo_o = {quo_i[W-2:0], 1'b1};
        end else begin
            rem_o = shifted[W-1:0];
            quo_o = {quo_i[W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/iter_muldiv.sv
module iter_muldiv
    import muldiv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic                          op_i,
    input  logic [WIDTH-1:0]              opa_i,
    input  logic [WIDTH-1:0]              opb_i,
    output logic                          busy_o,
    output logic                          done_o,
    output logic                          div_err_o,
    output logic [2*WIDTH-1:0]            product_o,
    output logic [WIDTH-1:0]              quotient_o,
    output logic [WIDTH-1:0]              remainder_o,
    output logic [$clog2(WIDTH+1)-1:0]    iter_count_o
);
    localparam int CNT_W = $clog2(WIDTH + 1);
    localparam int DW    = 2 * WIDTH;
    localparam logic [CNT_W-1:0] LAST_DIV = CNT_W'(WIDTH - 1);

    typedef struct packed {
        md_state_e         state;
        logic [DW-1:0]     work;
        logic [WIDTH-1:0]  opnd;
        logic [DW-1:0]     acc;
        logic [CNT_W-1:0]  cnt;
        logic              done;
        logic              err;
        logic [DW-1:0]     prod;
        logic [WIDTH-1:0]  quo;
        logic [WIDTH-1:0]  rem;
    } md_regs_t;

    md_regs_t r_q, r_d;

    logic [DW-1:0]    mul_mcand_d;
    logic [WIDTH-1:0] mul_mplier_d;
    logic [DW-1:0]    mul_acc_d;
    logic             mul_last;
    logic [WIDTH-1:0] div_rem_d;
    logic [WIDTH-1:0] div_quo_d;

    md_mul_step #(.W(WIDTH)) u_mul_step (
        .mcand_i  (r_q.work),
        .mplier_i (r_q.opnd),
        .acc_i    (r_q.acc),
        .mcand_o  (mul_mcand_d),
        .mplier_o (mul_mplier_d),
        .acc_o    (mul_acc_d),
        .last_o   (mul_last)
    );

    md_div_step #(.W(WIDTH)) u_div_step (
        .rem_i  (r_q.work[DW-1:WIDTH]),
        .quo_i  (r_q.work[WIDTH-1:0]),
        .dvsr_i (r_q.opnd),
        .rem_o  (div_rem_d),
        .quo_o  (div_quo_d)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.cnt  = '0;
                    r_d.opnd = opb_i;
                    r_d.acc  = '0;
                    r_d.work = {{WIDTH{1'b0}}, opa_i};
                    r_d.state = (op_i == OP_MUL) ? ST_MUL : ST_DIV;
                end
            end
            ST_MUL: begin
                r_d.work = mul_mcand_d;
                r_d.opnd = mul_mplier_d;
                r_d.acc  = mul_acc_d;
                r_d.cnt  = r_q.cnt + 1'b1;
                if (mul_last) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                    r_d.prod  = mul_acc_d;
                end
            end
            ST_DIV: begin
                if (r_q.opnd == '0) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                    r_d.err   = 1'b1;
                    r_d.quo   = '1;
                    r_d.rem   = '1;
                end else begin
                    r_d.work = {div_rem_d, div_quo_d};
                    r_d.cnt  = r_q.cnt + 1'b1;
                    if (r_q.cnt == LAST_DIV) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                        r_d.quo   = div_quo_d;
                        r_d.rem   = div_rem_d;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o       = (r_q.state != ST_IDLE);
    assign done_o       = r_q.done;
    assign div_err_o    = r_q.err;
    assign product_o    = r_q.prod;
    assign quotient_o   = r_q.quo;
    assign remainder_o  = r_q.rem;
    assign iter_count_o = r_q.cnt;

    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_results_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(product_o) && $stable(quotient_o) && $stable(remainder_o)));

    a_r6_err_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        div_err_o |-> (done_o && quotient_o == '1 && remainder_o == '1 && iter_count_o == '0));

    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (iter_count_o < CNT_W'(WIDTH)));

    a_r7_start_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (busy_o || done_o));
endmodule

// File: tb/iter_muldiv_tb.sv
module iter_muldiv_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        op_i = 1'b0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic        busy_o, done_o, div_err_o;
    logic [63:0] product_o;
    logic [31:0] quotient_o, remainder_o;
    logic [5:0]  iter_count_o;

    int checks = 0;
    int errors = 0;
    logic [63:0] last_prod = '0;
    logic [31:0] last_quo = '0;
    logic [31:0] last_rem = '0;

    always #2.5 clk = ~clk;

    iter_muldiv u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .opa_i(opa_i), .opb_i(opb_i), .busy_o(busy_o), .done_o(done_o),
        .div_err_o(div_err_o), .product_o(product_o), .quotient_o(quotient_o),
        .remainder_o(remainder_o), .iter_count_o(iter_count_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_mul_iters(input logic [31:0] b);
        int n = 1;
        for (int i = 0; i < 32; i++) if (b[i]) n = i + 1;
        return n;
    endfunction

    task automatic run_op(input logic op, input logic [31:0] a, input logic [31:0] b,
                          input bit poke);
        int lat;
        int exp_lat;
        int exp_cnt;
        @(negedge clk);
        start_i = 1'b1; op_i = op; opa_i = a; opb_i = b;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 100) begin
            if (poke && lat == 2) begin
                start_i = 1'b1; op_i = ~op; opa_i = $urandom; opb_i = $urandom;
            end else begin
                start_i = 1'b0;
            end
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        start_i = 1'b0;
        if (op == 1'b0) begin
            exp_cnt = exp_mul_iters(b);
            exp_lat = exp_cnt + 1;
            chk("R2 product", product_o, {32'b0, a} * {32'b0, b});
            chk("R3 mul latency", 64'(lat), 64'(exp_lat));
            chk("R3 mul count", 64'(iter_count_o), 64'(exp_cnt));
            chk("R9 quo kept by mul", {quotient_o, remainder_o}, {last_quo, last_rem});
            last_prod = {32'b0, a} * {32'b0, b};
        end else if (b == 0) begin
            chk("R6 err", 64'(div_err_o), 64'd1);
            chk("R6 latency", 64'(lat), 64'd2);
            chk("R6 ones", {quotient_o, remainder_o}, '1);
            chk("R6 count", 64'(iter_count_o), 64'd0);
            chk("R9 prod kept by div", product_o, last_prod);
            last_quo = '1; last_rem = '1;
        end else begin
            chk("R5 quotient", 64'(quotient_o), 64'(a / b));
            chk("R5 remainder", 64'(remainder_o), 64'(a % b));
            chk("R5 latency", 64'(lat), 64'd33);
            chk("R5 count", 64'(iter_count_o), 64'd32);
            chk("R9 prod kept by div", product_o, last_prod);
            last_quo = a / b; last_rem = a % b;
        end
        if (b != 0 || op == 1'b0) chk("R6 no err", 64'(div_err_o), 64'd0);
        chk("R8 not busy at done", 64'(busy_o), 64'd0);
        @(negedge clk);
        chk("R8 done pulse", 64'(done_o), 64'd0);
        @(negedge clk);
        chk("R8 results held", {product_o ^ {quotient_o, remainder_o}},
            {last_prod ^ {last_quo, last_rem}});
    endtask

    initial begin
        #(5ns * 190000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy", 64'(busy_o), 64'd0);
        chk("R1 done", 64'(done_o), 64'd0);
        chk("R1 err", 64'(div_err_o), 64'd0);
        chk("R1 outputs", product_o | {quotient_o, remainder_o} | 64'(iter_count_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R4: zero multiplier
        run_op(1'b0, 32'hDEAD_BEEF, 32'd0, 1'b0);
        run_op(1'b0, 32'hFFFF_FFFF, 32'd1, 1'b0);
        run_op(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        run_op(1'b0, 32'd7, 32'h8000_0000, 1'b0);
        run_op(1'b1, 32'd100, 32'd7, 1'b0);
        run_op(1'b1, 32'd5, 32'd0, 1'b0);
        run_op(1'b1, 32'hFFFF_FFFF, 32'd1, 1'b0);
        run_op(1'b1, 32'd3, 32'hFFFF_FFFF, 1'b0);
        // R7: stray start during busy
        run_op(1'b1, 32'h1234_5678, 32'd99, 1'b1);
        run_op(1'b0, 32'hCAFE_0001, 32'h00F0_0F00, 1'b1);
        for (int i = 0; i < 60; i++) begin
            logic [31:0] a = $urandom;
            logic [31:0] b = $urandom >> ($urandom % 32);
            run_op(1'($urandom % 2), a, b, ($urandom % 4) == 0);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule